// File: doc/BRIEF.md
# Command Queue Fetch and Dispatch

This block takes commands from the head of a ring of 128-bit command entries and hands each one to the unit that carries it out. Each entry is four 32-bit words. The ring's pointer logic sits outside the block. It reports whether a command is waiting (`cq_pending`) and presents the head entry on `cmd_entry`. When commands are enabled and one is waiting, the block reads the 8-bit opcode in the low byte of word 0 and sorts the command into one of four classes:

- configuration invalidate,
- translation-cache invalidate,
- sync,
- resume/stall.

The block then raises that class's request line. It holds the entry and its decoded address operand steady until the action unit acknowledges. After the acknowledge it emits one consumer-increment pulse so the ring can retire the entry.

Processing stops at the first bad command instead of skipping it. The block raises a global error flag and reports a typed error code: illegal opcode, fetch abort, or failed sync. It stays stalled, with the consumer pointer unchanged, until software clears the condition. A completed sync command can also raise a completion pulse. Word 0 bits 13:12 select whether that pulse is an interrupt or an event signal.

Top module: `cmdq_dispatch`

## Requirements
- R1: While reset is asserted and immediately after it, every request line, `cons_incr`, `sync_irq`, `sync_evt`, `err_flag`, `act_addr`, `act_entry` and `err_code` are zero.
- R2: A command is taken only on a clock edge where `cq_enable` and `cq_pending` are 1, no command is in flight, the block is not halted, and `cons_incr` is not high. Its request line is high from the following cycle.
- R3: Opcodes select exactly one request line:
  - `req_cfg` for 0x01–0x07.
  - `req_tlb` for 0x10–0x13, 0x18, 0x1A, 0x20–0x23, 0x28, 0x2A, 0x30 and 0x40.
  - `req_resume` for 0x41, 0x44 and 0x45.
  - `req_sync` for 0x46.
  - The line stays high until `act_ack` is sampled high.
- R4: While a request is high, `act_entry` equals the accepted entry. `act_addr` equals word 3 in bits 63:32, word 2 bits 31:12 in bits 31:12, and zero in bits 11:0. Both hold their value until the next command is taken.
- R5: On the edge where `act_ack` is sampled with a request high, the request drops and `cons_incr` is high for exactly one cycle.
- R6: An opcode of 0x00 or any value not listed in R3 raises no request and no `cons_incr`. It sets `err_flag` to 1 and `err_code` to 1 one cycle after being taken.
- R7: If `cmd_fetch_err` is 1 when a command is taken, `err_code` becomes 2 and `err_flag` 1 whatever the opcode, with no request.
- R8: A sync command with word 0 bits 13:12 equal to 1 pulses `sync_irq`, and with 2 pulses `sync_evt`. The pulse is in the same cycle as its `cons_incr`. Values 0 and 3 give no pulse.
- R9: `act_fail` sampled with `act_ack` on a sync request sets `err_code` 3 and `err_flag` 1 with no `cons_incr`. For any other class `act_fail` is ignored.
- R10: Once set, `err_flag` and `err_code` hold until `err_clear` is sampled high. Both then return to zero and fetching resumes. `err_clear` has no effect when not halted.
- R11: With `cq_enable` low no command is taken. A request already raised still completes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cq_enable | input | 1 | Command consumption enable |
| cq_pending | input | 1 | Ring holds at least one command |
| cmd_entry | input | 128 | Head entry, word 0 in bits 31:0 |
| cmd_fetch_err | input | 1 | Reading the head entry aborted |
| act_ack | input | 1 | Action unit finished the current request |
| act_fail | input | 1 | Qualifies `act_ack`: the sync failed |
| err_clear | input | 1 | Software clears a halt |
| req_cfg | output | 1 | Configuration-invalidate request |
| req_tlb | output | 1 | Translation-cache invalidate request |
| req_sync | output | 1 | Sync request |
| req_resume | output | 1 | Resume/stall/page-response request |
| act_entry | output | 128 | Entry of the current command |
| act_addr | output | 64 | Decoded address operand |
| cons_incr | output | 1 | One-cycle pulse: retire the head entry |
| sync_irq | output | 1 | Sync completion interrupt pulse |
| sync_evt | output | 1 | Sync completion event pulse |
| err_flag | output | 1 | Halted on an error |
| err_code | output | 2 | 0 none, 1 illegal, 2 fetch abort, 3 sync failure |

## Verification
The assertions assume two things about the inputs:
- `act_ack` is raised only while a request line is high and is dropped once the request falls.
- The ring stops asserting `cq_pending` for an entry after its `cons_incr`.

The stimulus responds to requests after a programmable delay of zero to five cycles and never acknowledges an idle block. It retires the head entry on each `cons_incr`. It also removes a halting entry itself before pulsing `err_clear`, which is how the surrounding software is expected to repair the ring.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 4;
    localparam int OPC_W     = 8;
    localparam int PG_BITS   = 12;
    localparam int CS_LSB    = 12;
    localparam int NUM_CLS   = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_HALT = 2'd2
    } seq_st_e;

    typedef enum logic [1:0] {
        CL_CFG    = 2'd0,
        CL_TLB    = 2'd1,
        CL_SYNC   = 2'd2,
        CL_RESUME = 2'd3
    } cmd_cls_e;

    typedef enum logic [1:0] {
        ER_NONE     = 2'd0,
        ER_ILLEGAL  = 2'd1,
        ER_FETCH    = 2'd2,
        ER_SYNCFAIL = 2'd3
    } cmd_err_e;

    localparam logic [1:0] SIG_IRQ = 2'd1;
    localparam logic [1:0] SIG_EVT = 2'd2;

endpackage

// File: rtl/cmdq_opclass.sv
module cmdq_opclass
    import cmdq_pkg::*;
#(
    parameter int OPC_W = cmdq_pkg::OPC_W
) (
    input  logic [OPC_W-1:0] opc,
    output logic             legal,
    output cmd_cls_e         cls
);

    always_comb begin
        legal = 1'b1;
        cls   = CL_CFG;
        case (opc)
            8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07:
                cls = CL_CFG;
            8'h10, 8'h11, 8'h12, 8'h13, 8'h18, 8'h1A,
            8'h20, 8'h21, 8'h22, 8'h23, 8'h28, 8'h2A,
            8'h30, 8'h40:
                cls = CL_TLB;
            8'h41, 8'h44, 8'h45:
                cls = CL_RESUME;
            8'h46:
                cls = CL_SYNC;
            default: begin
                legal = 1'b0;
                cls   = CL_CFG;
            end
        endcase
    end

endmodule

// File: rtl/cmdq_operand.sv
module cmdq_operand #(
    parameter int WORD_W  = cmdq_pkg::WORD_W,
    parameter int PG_BITS = cmdq_pkg::PG_BITS,
    localparam int ADDR_W = 2 * WORD_W
) (
    input  logic [WORD_W-PG_BITS-1:0] w2_hi,
    input  logic [WORD_W-1:0]         w3,
    output logic [ADDR_W-1:0]         addr
);

    always_comb begin
        addr = {w3, w2_hi, {PG_BITS{1'b0}}};
    end

endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
    import cmdq_pkg::*;
#(
    parameter int ENTRY_W = 128,
    parameter int ADDR_W  = 64,
    parameter int NCLS    = cmdq_pkg::NUM_CLS,
    parameter int CS_POS  = cmdq_pkg::CS_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cq_enable,
    input  logic               cq_pending,
    input  logic               cmd_fetch_err,
    input  logic [ENTRY_W-1:0] entry_in,
    input  logic               op_legal,
    input  cmd_cls_e           op_cls,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic               act_ack,
    input  logic               act_fail,
    input  logic               err_clear,
    output logic [NCLS-1:0]    req,
    output logic [ENTRY_W-1:0] act_entry,
    output logic [ADDR_W-1:0]  act_addr,
    output logic               cons_incr,
    output logic               sync_irq,
    output logic               sync_evt,
    output logic               err_flag,
    output logic [1:0]         err_code
);

    typedef struct packed {
        seq_st_e            st;
        cmd_cls_e           cls;
        logic [ENTRY_W-1:0] entry;
        logic [ADDR_W-1:0]  addr;
        logic               incr;
        logic               irq;
        logic               evt;
        cmd_err_e           code;
    } seq_t;

    seq_t s_d, s_q;
    logic [1:0] cs_fld;

    assign cs_fld = s_q.entry[CS_POS+1:CS_POS];

    always_comb begin
        s_d      = s_q;
        s_d.incr = 1'b0;
        s_d.irq  = 1'b0;
        s_d.evt  = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (cq_enable && cq_pending && !s_q.incr) begin
                    if (cmd_fetch_err) begin
                        s_d.st   = ST_HALT;
                        s_d.code = ER_FETCH;
                    end else if (!op_legal) begin
                        s_d.st   = ST_HALT;
                        s_d.code = ER_ILLEGAL;
                    end else begin
                        s_d.st    = ST_BUSY;
                        s_d.cls   = op_cls;
                        s_d.entry = entry_in;
                        s_d.addr  = addr_in;
                    end
                end
            end
            ST_BUSY: begin
                if (act_ack) begin
                    if (s_q.cls == CL_SYNC && act_fail) begin
                        s_d.st   = ST_HALT;
                        s_d.code = ER_SYNCFAIL;
                    end else begin
                        s_d.st   = ST_IDLE;
                        s_d.incr = 1'b1;
                        s_d.irq  = (s_q.cls == CL_SYNC) && (cs_fld == SIG_IRQ);
                        s_d.evt  = (s_q.cls == CL_SYNC) && (cs_fld == SIG_EVT);
                    end
                end
            end
            ST_HALT: begin
                if (err_clear) begin
                    s_d.st   = ST_IDLE;
                    s_d.code = ER_NONE;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < NCLS; g++) begin : g_req
        assign req[g] = (s_q.st == ST_BUSY) && (s_q.cls == cmd_cls_e'(g));
    end

    assign act_entry = s_q.entry;
    assign act_addr  = s_q.addr;
    assign cons_incr = s_q.incr;
    assign sync_irq  = s_q.irq;
    assign sync_evt  = s_q.evt;
    assign err_flag  = (s_q.st == ST_HALT);
    assign err_code  = s_q.code;

endmodule

// File: rtl/cmdq_dispatch.sv
module cmdq_dispatch
    import cmdq_pkg::*;
#(
    parameter int  WW      = cmdq_pkg::WORD_W,
    parameter int  NW      = cmdq_pkg::NUM_WORDS,
    parameter int  OW      = cmdq_pkg::OPC_W,
    parameter int  PGB     = cmdq_pkg::PG_BITS,
    localparam int ENTRY_W = WW * NW,
    localparam int ADDR_W  = 2 * WW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cq_enable,
    input  logic               cq_pending,
    input  logic [ENTRY_W-1:0] cmd_entry,
    input  logic               cmd_fetch_err,
    input  logic               act_ack,
    input  logic               act_fail,
    input  logic               err_clear,
    output logic               req_cfg,
    output logic               req_tlb,
    output logic               req_sync,
    output logic               req_resume,
    output logic [ENTRY_W-1:0] act_entry,
    output logic [ADDR_W-1:0]  act_addr,
    output logic               cons_incr,
    output logic               sync_irq,
    output logic               sync_evt,
    output logic               err_flag,
    output logic [1:0]         err_code
);

    logic               legal;
    cmd_cls_e           cls;
    logic [ADDR_W-1:0]  addr;
    logic [NUM_CLS-1:0] req;

    cmdq_opclass #(.OPC_W(OW)) u_opclass (
        .opc   (cmd_entry[OW-1:0]),
        .legal (legal),
        .cls   (cls)
    );

    cmdq_operand #(.WORD_W(WW), .PG_BITS(PGB)) u_operand (
        .w2_hi (cmd_entry[3*WW-1:2*WW+PGB]),
        .w3    (cmd_entry[4*WW-1:3*WW]),
        .addr  (addr)
    );

    cmdq_seq #(
        .ENTRY_W (ENTRY_W),
        .ADDR_W  (ADDR_W),
        .NCLS    (NUM_CLS),
        .CS_POS  (CS_LSB)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cq_enable     (cq_enable),
        .cq_pending    (cq_pending),
        .cmd_fetch_err (cmd_fetch_err),
        .entry_in      (cmd_entry),
        .op_legal      (legal),
        .op_cls        (cls),
        .addr_in       (addr),
        .act_ack       (act_ack),
        .act_fail      (act_fail),
        .err_clear     (err_clear),
        .req           (req),
        .act_entry     (act_entry),
        .act_addr      (act_addr),
        .cons_incr     (cons_incr),
        .sync_irq      (sync_irq),
        .sync_evt      (sync_evt),
        .err_flag      (err_flag),
        .err_code      (err_code)
    );

    assign req_cfg    = req[CL_CFG];
    assign req_tlb    = req[CL_TLB];
    assign req_sync   = req[CL_SYNC];
    assign req_resume = req[CL_RESUME];

endmodule

// File: rtl/cmdq_dispatch_chk.sv
module cmdq_dispatch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cq_enable,
    input logic        cq_pending,
    input logic        act_ack,
    input logic        act_fail,
    input logic        err_clear,
    input logic        req_cfg,
    input logic        req_tlb,
    input logic        req_sync,
    input logic        req_resume,
    input logic [63:0] act_addr,
    input logic        cons_incr,
    input logic        sync_irq,
    input logic        sync_evt,
    input logic        err_flag,
    input logic [1:0]  err_code
);

    logic [3:0] reqs;
    logic       any_req;

    assign reqs    = {req_resume, req_sync, req_tlb, req_cfg};
    assign any_req = |reqs;

    a_r3_one_class: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reqs));

    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && !act_ack) |=> ($stable(reqs) && $stable(act_addr)));

    a_r2_take_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_req) |-> $past(cq_enable && cq_pending));

    a_r5_incr_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cons_incr |-> $past(act_ack && any_req));

    a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && act_ack) |=> !any_req);

    a_r6_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (!any_req && !cons_incr && err_code != 2'd0));

    a_r8_sync_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_irq || sync_evt) |-> (cons_incr && !(sync_irq && sync_evt)));

    a_r9_sync_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (req_sync && act_ack && act_fail) |=> (err_flag && err_code == 2'd3 && !cons_incr));

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clear) |=> (err_flag && $stable(err_code)));

endmodule

bind cmdq_dispatch cmdq_dispatch_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cq_enable  (cq_enable),
    .cq_pending (cq_pending),
    .act_ack    (act_ack),
    .act_fail   (act_fail),
    .err_clear  (err_clear),
    .req_cfg    (req_cfg),
    .req_tlb    (req_tlb),
    .req_sync   (req_sync),
    .req_resume (req_resume),
    .act_addr   (act_addr),
    .cons_incr  (cons_incr),
    .sync_irq   (sync_irq),
    .sync_evt   (sync_evt),
    .err_flag   (err_flag),
    .err_code   (err_code)
);

// File: tb/cmdq_dispatch_bench.sv
`timescale 1ns/1ps
module cmdq_dispatch_bench;

    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cq_enable = 1'b0;
    logic         cq_pending = 1'b0;
    logic [127:0] cmd_entry = '0;
    logic         cmd_fetch_err = 1'b0;
    logic         act_ack = 1'b0;
    logic         act_fail = 1'b0;
    logic         err_clear = 1'b0;
    logic         req_cfg, req_tlb, req_sync, req_resume;
    logic [127:0] act_entry;
    logic [63:0]  act_addr;
    logic         cons_incr, sync_irq, sync_evt, err_flag;
    logic [1:0]   err_code;

    always #(PERIOD/2) clk = ~clk;

    cmdq_dispatch u_cmdq_dispatch (
        .clk(clk), .rst_n(rst_n), .cq_enable(cq_enable), .cq_pending(cq_pending),
        .cmd_entry(cmd_entry), .cmd_fetch_err(cmd_fetch_err), .act_ack(act_ack),
        .act_fail(act_fail), .err_clear(err_clear), .req_cfg(req_cfg),
        .req_tlb(req_tlb), .req_sync(req_sync), .req_resume(req_resume),
        .act_entry(act_entry), .act_addr(act_addr), .cons_incr(cons_incr),
        .sync_irq(sync_irq), .sync_evt(sync_evt), .err_flag(err_flag),
        .err_code(err_code)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // ring contents as seen by the block
    logic [127:0] q_entry[$];
    bit           q_ferr[$];
    int           ack_delay = 0;
    int           ack_cnt = 0;

    always @(negedge clk) begin
        if (cons_incr && q_entry.size() > 0) begin
            void'(q_entry.pop_front());
            void'(q_ferr.pop_front());
        end
        cq_pending    = (q_entry.size() > 0);
        cmd_entry     = (q_entry.size() > 0) ? q_entry[0] : '0;
        cmd_fetch_err = (q_ferr.size() > 0) ? q_ferr[0] : 1'b0;
        if (req_cfg || req_tlb || req_sync || req_resume) begin
            if (ack_cnt >= ack_delay) begin
                act_ack = 1'b1;
                ack_cnt = 0;
            end else begin
                act_ack = 1'b0;
                ack_cnt++;
            end
        end else begin
            act_ack = 1'b0;
            ack_cnt = 0;
        end
    end

    // behavioural reference
    int unsigned legal_tab[25] = '{1, 2, 3, 4, 5, 6, 7, 16, 17, 18, 19, 24, 26,
                                   32, 33, 34, 35, 40, 42, 48, 64, 65, 68, 69, 70};

    function automatic bit is_legal(int unsigned op);
        foreach (legal_tab[i]) if (legal_tab[i] == op) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int class_of(int unsigned op);
        if (op < 8) return 0;
        if (op == 70) return 2;
        if (op == 65 || op == 68 || op == 69) return 3;
        return 1;
    endfunction

    int           m_st = 0;
    int           m_cls = 0;
    logic [127:0] m_entry = '0;
    logic [63:0]  m_addr = '0;
    bit           m_incr = 0, m_irq = 0, m_evt = 0;
    int           m_code = 0;

    always @(posedge clk) begin
        bit n_incr, n_irq, n_evt;
        int cs;
        n_incr = 0; n_irq = 0; n_evt = 0;
        if (!rst_n) begin
            m_st = 0; m_cls = 0; m_entry = '0; m_addr = '0; m_code = 0;
        end else begin
            if (m_st == 0) begin
                if (cq_enable && cq_pending && !m_incr) begin
                    if (cmd_fetch_err) begin
                        m_st = 2; m_code = 2;
                    end else if (!is_legal(int'(cmd_entry[7:0]))) begin
                        m_st = 2; m_code = 1;
                    end else begin
                        m_st = 1;
                        m_cls = class_of(int'(cmd_entry[7:0]));
                        m_entry = cmd_entry;
                        m_addr = {cmd_entry[127:96], cmd_entry[95:76], 12'h000};
                    end
                end
            end else if (m_st == 1) begin
                if (act_ack) begin
                    if (m_cls == 2 && act_fail) begin
                        m_st = 2; m_code = 3;
                    end else begin
                        cs = int'(m_entry[13:12]);
                        m_st = 0;
                        n_incr = 1;
                        n_irq = (m_cls == 2) && (cs == 1);
                        n_evt = (m_cls == 2) && (cs == 2);
                    end
                end
            end else begin
                if (err_clear) begin
                    m_st = 0; m_code = 0;
                end
            end
        end
        m_incr = n_incr; m_irq = n_irq; m_evt = n_evt;
    end

    int incr_seen = 0, irq_seen = 0, evt_seen = 0;

    always @(posedge clk) begin
        #1;
        chk(req_cfg    == (m_st == 1 && m_cls == 0), "R3", "req_cfg",    128'(req_cfg),    128'(m_st == 1 && m_cls == 0));
        chk(req_tlb    == (m_st == 1 && m_cls == 1), "R3", "req_tlb",    128'(req_tlb),    128'(m_st == 1 && m_cls == 1));
        chk(req_sync   == (m_st == 1 && m_cls == 2), "R2", "req_sync",   128'(req_sync),   128'(m_st == 1 && m_cls == 2));
        chk(req_resume == (m_st == 1 && m_cls == 3), "R3", "req_resume", 128'(req_resume), 128'(m_st == 1 && m_cls == 3));
        chk(act_entry == m_entry, "R4", "act_entry", act_entry, m_entry);
        chk(act_addr == m_addr, "R4", "act_addr", 128'(act_addr), 128'(m_addr));
        chk(cons_incr == m_incr, "R5", "cons_incr", 128'(cons_incr), 128'(m_incr));
        chk(sync_irq == m_irq, "R8", "sync_irq", 128'(sync_irq), 128'(m_irq));
        chk(sync_evt == m_evt, "R8", "sync_evt", 128'(sync_evt), 128'(m_evt));
        chk(err_flag == (m_st == 2), "R10", "err_flag", 128'(err_flag), 128'(m_st == 2));
        chk(int'(err_code) == m_code, (m_code == 3) ? "R9" : (m_code == 2) ? "R7" : "R6",
            "err_code", 128'(err_code), 128'(m_code));
        if (cons_incr) incr_seen++;
        if (sync_irq)  irq_seen++;
        if (sync_evt)  evt_seen++;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    function automatic logic [127:0] mk(input int unsigned op, input int unsigned cs,
                                        input logic [31:0] w2, input logic [31:0] w3);
        logic [31:0] w0;
        w0 = {18'h2A5A5, cs[1:0], 4'hC, op[7:0]};
        return {w3, w2, 32'hC0DE_0001 ^ w3, w0};
    endfunction

    task automatic push(input logic [127:0] e, input bit ferr);
        q_entry.push_back(e);
        q_ferr.push_back(ferr);
    endtask

    task automatic drain();
        for (int i = 0; i < 80; i++) begin
            if ((q_entry.size() == 0 && m_st == 0) || m_st == 2) break;
            step(1);
        end
        step(2);
    endtask

    task automatic recover();
        if (q_entry.size() > 0) begin
            void'(q_entry.pop_front());
            void'(q_ferr.pop_front());
        end
        err_clear = 1'b1;
        step(1);
        err_clear = 1'b0;
        step(1);
    endtask

    task automatic run_all();
        int base;
        step(3);
        chk(!err_flag && !cons_incr && !req_cfg && !req_tlb && !req_sync && !req_resume
            && act_addr == 0 && err_code == 0, "R1", "reset outputs",
            {err_flag, cons_incr, req_cfg, req_tlb, req_sync, req_resume}, 128'd0);
        rst_n = 1'b1;
        step(1);
        chk(act_entry == 0 && !err_flag, "R1", "after reset", act_entry, 128'd0);

        // one of each class plus every completion-signal value
        cq_enable = 1'b1;
        base = incr_seen;
        ack_delay = 2;
        push(mk(8'h03, 0, 32'h1234_5678, 32'hAABB_CCDD), 0);
        push(mk(8'h12, 1, 32'hFFFF_F001, 32'h0000_0007), 0);
        push(mk(8'h44, 0, 32'h0, 32'h0), 0);
        push(mk(8'h46, 1, 32'h0, 32'h0), 0);
        push(mk(8'h46, 2, 32'h0, 32'h0), 0);
        push(mk(8'h46, 0, 32'h0, 32'h0), 0);
        push(mk(8'h46, 3, 32'h0, 32'h0), 0);
        drain();
        chk(incr_seen - base == 7, "R5", "retired count", 128'(incr_seen - base), 128'd7);
        chk(irq_seen == 1, "R8", "irq pulses", 128'(irq_seen), 128'd1);
        chk(evt_seen == 1, "R8", "evt pulses", 128'(evt_seen), 128'd1);

        // immediate acknowledge, back-to-back
        ack_delay = 0;
        base = incr_seen;
        push(mk(8'h2A, 0, 32'h8000_0FFF, 32'h1), 0);
        push(mk(8'h01, 0, 32'h0, 32'h0), 0);
        drain();
        chk(incr_seen - base == 2, "R5", "back-to-back", 128'(incr_seen - base), 128'd2);

        // enable low blocks taking a command
        cq_enable = 1'b0;
        base = incr_seen;
        push(mk(8'h10, 0, 32'h0, 32'h0), 0);
        step(20);
        chk(q_entry.size() == 1 && incr_seen == base, "R11", "enable low holds",
            128'(q_entry.size()), 128'd1);
        cq_enable = 1'b1;
        drain();
        chk(q_entry.size() == 0, "R2", "taken when enabled", 128'(q_entry.size()), 128'd0);

        // enable dropped while busy: request still completes
        ack_delay = 5;
        push(mk(8'h20, 0, 32'h0, 32'h0), 0);
        step(4);
        cq_enable = 1'b0;
        step(12);
        chk(q_entry.size() == 0, "R11", "in-flight completes", 128'(q_entry.size()), 128'd0);
        cq_enable = 1'b1;
        ack_delay = 1;

        // illegal opcode
        base = incr_seen;
        push(mk(8'h00, 0, 32'h0, 32'h0), 0);
        step(6);
        chk(err_flag && err_code == 2'd1 && incr_seen == base, "R6", "illegal halt",
            128'(err_code), 128'd1);
        step(5);
        chk(err_flag && err_code == 2'd1, "R10", "halt sticky", 128'(err_code), 128'd1);
        recover();
        chk(!err_flag && err_code == 2'd0, "R10", "cleared", 128'(err_code), 128'd0);

        // fetch abort wins over a legal opcode
        push(mk(8'h46, 1, 32'h0, 32'h0), 1);
        step(6);
        chk(err_flag && err_code == 2'd2, "R7", "fetch abort", 128'(err_code), 128'd2);
        recover();

        // sync failure, then failure flag ignored for another class
        act_fail = 1'b1;
        base = incr_seen;
        push(mk(8'h46, 1, 32'h0, 32'h0), 0);
        drain();
        chk(err_flag && err_code == 2'd3 && incr_seen == base, "R9", "sync fail",
            128'(err_code), 128'd3);
        recover();
        push(mk(8'h11, 0, 32'h0, 32'h0), 0);
        drain();
        chk(!err_flag && incr_seen == base + 1, "R9", "fail ignored non-sync",
            128'(incr_seen - base), 128'd1);
        act_fail = 1'b0;

        // clear when not halted does nothing
        err_clear = 1'b1;
        step(1);
        err_clear = 1'b0;
        step(1);
        chk(!err_flag && err_code == 2'd0, "R10", "idle clear no effect", 128'(err_code), 128'd0);

        // every opcode value
        for (int op = 0; op < 256; op++) begin
            ack_delay = op % 4;
            push(mk(op, op % 4, 32'(op * 32'h0101_0101), 32'(~op)), 0);
            drain();
            chk(err_flag == !is_legal(op), is_legal(op) ? "R3" : "R6", "opcode sweep",
                128'(op), 128'(is_legal(op)));
            if (err_flag) recover();
        end
        step(4);
    endtask

    initial begin
        bit timed_out;
        timed_out = 0;
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        if (timed_out) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule